// File: doc/BRIEF.md
# Compact 12-bit Floating-Point Adder/Multiplier

This block is a purely combinational arithmetic unit for a small 12-bit floating-point format. It takes two operand words and a two-bit operation code. It returns the correctly rounded sum, difference or product, and a flag that says whether the operation code was legal. The intended use is in datapaths that need a little dynamic range at very low area, such as weighting and comparison of small counts.

Each word has three fields. The sign is the most significant bit. The next four bits hold an exponent stored with an offset of seven. The low seven bits hold the fraction, which sits below an implied leading one. An exponent field of zero stands for zero, so values too small to normalise are flushed. An exponent field of all ones stands for infinity when the fraction is zero and for not-a-number (NaN) otherwise. Every finite result is rounded to nearest, and exact ties go to the even fraction.

Top module: `fpu12_arith`

## Requirements
- R1: A word with sign s, exponent field e (bits 10:7) in 1..14 and fraction f (bits 6:0) has the value (-1)^s * (1 + f/128) * 2^(e-7). Any input whose exponent field is 0 is treated as zero, whatever its fraction.
- R2: op_i = 0 selects add, 1 selects subtract and 2 selects multiply, and valid_o is 1 for these codes. For op_i = 3, valid_o is 0 and res_o is 12'h000.
- R3: For add with finite non-zero operands, res_o is the exact sum of the two operands rounded to the format.
- R4: Subtract gives the same result as add with the sign bit of b_i inverted.
- R5: For multiply with finite non-zero operands, res_o is the exact product rounded to the format.
- R6: Rounding is to nearest. A discarded part of exactly half a unit in the last place rounds to the even fraction (for example 12'h500 + 12'h100 = 12'h500 and 12'h501 + 12'h100 = 12'h502).
- R7: When rounding carries out of the fraction, the fraction becomes 0 and the exponent field goes up by one (12'h5FF + 12'h180 = 12'h600).
- R8: A rounded result whose exponent field would be 15 or more becomes infinity with the result's sign: exponent field 4'hF and fraction 0 (12'h780 or 12'hF80).
- R9: Every zero result, whether from exact cancellation, a zero operand in a multiply, or a rounded exponent field of 0 or less, is the all-zero word 12'h000.
- R10: If either input is a NaN, or the operation is infinity minus infinity (after the subtract sign flip) or infinity times zero, res_o is the canonical NaN 12'h7FF.
- R11: Infinity plus a finite value gives that infinity. Infinity times a non-zero finite value gives infinity whose sign is the XOR of the operand signs. Zero plus a finite non-zero x gives x unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 12 | First operand word |
| b_i | input | 12 | Second operand word |
| op_i | input | 2 | Operation code: 0 add, 1 subtract, 2 multiply, 3 unused |
| res_o | output | 12 | Rounded result word |
| valid_o | output | 1 | High when op_i selects a defined operation |

## Verification
Both res_o and valid_o are combinational functions of the current inputs, so each result is due in the same cycle as its stimulus and no register lies on the way. The bench applies each operand pair and operation code just after a falling clock edge. It samples two nanoseconds later, well clear of the next rising edge, once the combinational paths have settled. The expected words come from a real-valued model that forms the exact sum or product and rounds it to the format on its own. This model is used for a sweep over every first operand against a mix of second operands, and for directed tie, carry, overflow, underflow and special-value cases.

// File: rtl/fpu12_pkg.sv
package fpu12_pkg;

   typedef enum logic [1:0] {
      OP_ADD  = 2'd0,
      OP_SUB  = 2'd1,
      OP_MUL  = 2'd2,
      OP_NONE = 2'd3
   } fpu_op_e;

endpackage

// File: rtl/fpu12_addpath.sv
module fpu12_addpath #(
   parameter int EXP_W = 4,
   parameter int MAN_W = 7
) (
   input  logic                 sa_i,
   input  logic                 sb_i,
   input  logic [EXP_W-1:0]     ea_i,
   input  logic [EXP_W-1:0]     eb_i,
   input  logic [MAN_W-1:0]     ma_i,
   input  logic [MAN_W-1:0]     mb_i,
   output logic                 s_o,
   output logic signed [EXP_W+2:0] e_o,
   output logic [MAN_W+3:0]     sig_o,
   output logic                 zero_o
);
   localparam int SW = MAN_W + 1;
   localparam int EW = SW + 3;
   localparam int EI = EXP_W + 3;

   logic             a_big;
   logic [EXP_W-1:0] e_big, e_sml, diff;
   logic [EW-1:0]    x_big, x_sml, x_aln;
   logic [2*EW-1:0]  wide;
   logic [EW:0]      sum;
   int               sh, lead, lz;

   always_comb begin
      a_big = {ea_i, ma_i} >= {eb_i, mb_i};
      e_big = a_big ? ea_i : eb_i;
      e_sml = a_big ? eb_i : ea_i;
      x_big = {1'b1, (a_big ? ma_i : mb_i), 3'b000};
      x_sml = {1'b1, (a_big ? mb_i : ma_i), 3'b000};
      diff  = e_big - e_sml;
      sh    = (int'(diff) > EW + 1) ? EW + 1 : int'(diff);
      wide  = {x_sml, {EW{1'b0}}} >> sh;
      x_aln = wide[2*EW-1:EW] | {{(EW-1){1'b0}}, |wide[EW-1:0]};
      if (sa_i == sb_i) sum = {1'b0, x_big} + {1'b0, x_aln};
      else              sum = {1'b0, x_big} - {1'b0, x_aln};
      s_o    = a_big ? sa_i : sb_i;
      zero_o = (sum == '0);
      lead   = 0;
      for (int i = 0; i <= EW; i++) begin
         if (sum[i]) lead = i;
      end
      lz = EW - 1 - lead;
      if (sum[EW]) begin
         sig_o = sum[EW:1] | {{(EW-1){1'b0}}, sum[0]};
         e_o   = EI'(e_big) + EI'(1);
      end else begin
         sig_o = sum[EW-1:0] << lz;
         e_o   = EI'(e_big) - EI'(lz);
      end
   end

   // R3: a non-zero sum leaves normalisation with its leading one on top
   always_comb begin
      if (!zero_o)
         a_r3_sum_normalised: assert (sig_o[EW-1] == 1'b1)
            else $error("add path left an unnormalised significand");
   end

endmodule

// File: rtl/fpu12_mulpath.sv
module fpu12_mulpath #(
   parameter int EXP_W = 4,
   parameter int MAN_W = 7
) (
   input  logic                 sa_i,
   input  logic                 sb_i,
   input  logic [EXP_W-1:0]     ea_i,
   input  logic [EXP_W-1:0]     eb_i,
   input  logic [MAN_W-1:0]     ma_i,
   input  logic [MAN_W-1:0]     mb_i,
   output logic                 s_o,
   output logic signed [EXP_W+2:0] e_o,
   output logic [MAN_W+3:0]     sig_o
);
   localparam int SW   = MAN_W + 1;
   localparam int EI   = EXP_W + 3;
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;

   logic [2*SW-1:0] prod, norm;
   logic            hi;

   always_comb begin
      prod  = (2*SW)'({1'b1, ma_i}) * (2*SW)'({1'b1, mb_i});
      hi    = prod[2*SW-1];
      norm  = hi ? prod : (prod << 1);
      sig_o = {norm[2*SW-1 -: SW+2], |norm[SW-3:0]};
      e_o   = EI'(ea_i) + EI'(eb_i) - EI'(BIAS) + EI'(hi);
      s_o   = sa_i ^ sb_i;
   end

   // R5: the product of two normalised significands is never below one
   always_comb begin
      a_r5_product_normalised: assert (sig_o[MAN_W+3] == 1'b1 && prod != '0)
         else $error("multiply path left an unnormalised significand");
   end

endmodule

// File: rtl/fpu12_round.sv
module fpu12_round #(
   parameter int EXP_W = 4,
   parameter int MAN_W = 7
) (
   input  logic                    s_i,
   input  logic signed [EXP_W+2:0] e_i,
   input  logic [MAN_W+3:0]        sig_i,
   input  logic                    zero_i,
   output logic [EXP_W+MAN_W:0]    res_o
);
   localparam int SW   = MAN_W + 1;
   localparam int EI   = EXP_W + 3;
   localparam int EMAX = (1 << EXP_W) - 1;
   localparam logic signed [EI-1:0] EMAX_S = EI'(EMAX);
   localparam logic signed [EI-1:0] ZERO_S = '0;

   logic [SW-1:0]          keep;
   logic                   guard, sticky, up, carry;
   logic [SW:0]            r;
   logic signed [EI-1:0]   e2;
   logic [MAN_W-1:0]       mant;

   always_comb begin
      keep   = sig_i[MAN_W+3:3];
      guard  = sig_i[2];
      sticky = |sig_i[1:0];
      up     = guard & (sticky | keep[0]);
      r      = {1'b0, keep} + {{SW{1'b0}}, up};
      carry  = r[SW];
      e2     = e_i + EI'(carry);
      mant   = carry ? '0 : r[MAN_W-1:0];
      if (zero_i || e2 <= ZERO_S)
         res_o = '0;
      else if (e2 >= EMAX_S)
         res_o = {s_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      else
         res_o = {s_i, e2[EXP_W-1:0], mant};
   end

   // R7: a carry out of rounding only happens from an all-ones significand
   always_comb begin
      if (carry)
         a_r7_carry_from_ones: assert (keep == '1)
            else $error("rounding carried from a non-saturated significand");
   end

endmodule

// File: rtl/fpu12_arith.sv
module fpu12_arith
   import fpu12_pkg::*;
#(
   parameter int EXP_W = 4,
   parameter int MAN_W = 7
) (
   input  logic [EXP_W+MAN_W:0] a_i,
   input  logic [EXP_W+MAN_W:0] b_i,
   input  logic [1:0]           op_i,
   output logic [EXP_W+MAN_W:0] res_o,
   output logic                 valid_o
);
   localparam int WW   = EXP_W + MAN_W + 1;
   localparam int EI   = EXP_W + 3;
   localparam int EMAX = (1 << EXP_W) - 1;
   localparam logic [WW-1:0] NAN_W = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b1}}};

   if (EXP_W < 3) begin : g_bad_exp
      $error("EXP_W must be at least 3");
   end
   if (MAN_W < 2) begin : g_bad_man
      $error("MAN_W must be at least 2");
   end

   fpu_op_e          op;
   logic             sa, sb, sb_eff;
   logic [EXP_W-1:0] ea, eb;
   logic [MAN_W-1:0] ma, mb;
   logic             a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;

   always_comb begin
      op     = fpu_op_e'(op_i);
      {sa, ea, ma} = a_i;
      {sb, eb, mb} = b_i;
      sb_eff = sb ^ (op == OP_SUB);
      a_zero = (ea == '0);
      b_zero = (eb == '0);
      a_inf  = (ea == EXP_W'(EMAX)) && (ma == '0);
      b_inf  = (eb == EXP_W'(EMAX)) && (mb == '0);
      a_nan  = (ea == EXP_W'(EMAX)) && (ma != '0);
      b_nan  = (eb == EXP_W'(EMAX)) && (mb != '0);
   end

   logic                 add_s, add_zero, mul_s;
   logic signed [EI-1:0] add_e, mul_e;
   logic [MAN_W+3:0]     add_sig, mul_sig;

   fpu12_addpath #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_add (
      .sa_i(sa), .sb_i(sb_eff), .ea_i(ea), .eb_i(eb), .ma_i(ma), .mb_i(mb),
      .s_o(add_s), .e_o(add_e), .sig_o(add_sig), .zero_o(add_zero)
   );

   fpu12_mulpath #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_mul (
      .sa_i(sa), .sb_i(sb), .ea_i(ea), .eb_i(eb), .ma_i(ma), .mb_i(mb),
      .s_o(mul_s), .e_o(mul_e), .sig_o(mul_sig)
   );

   logic                 rs;
   logic signed [EI-1:0] re;
   logic [MAN_W+3:0]     rsig;
   logic                 rzero;
   logic [WW-1:0]        rounded;

   always_comb begin
      if (op == OP_MUL) begin
         rs = mul_s; re = mul_e; rsig = mul_sig; rzero = 1'b0;
      end else begin
         rs = add_s; re = add_e; rsig = add_sig; rzero = add_zero;
      end
   end

   fpu12_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
      .s_i(rs), .e_i(re), .sig_i(rsig), .zero_i(rzero), .res_o(rounded)
   );

   always_comb begin
      valid_o = (op != OP_NONE);
      res_o   = rounded;
      case (op)
         OP_ADD, OP_SUB: begin
            if (a_nan || b_nan)                       res_o = NAN_W;
            else if (a_inf && b_inf && sa != sb_eff)  res_o = NAN_W;
            else if (a_inf)  res_o = {sa, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            else if (b_inf)  res_o = {sb_eff, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            else if (a_zero && b_zero)                res_o = '0;
            else if (a_zero) res_o = {sb_eff, eb, mb};
            else if (b_zero) res_o = a_i;
         end
         OP_MUL: begin
            if (a_nan || b_nan)                                res_o = NAN_W;
            else if ((a_inf && b_zero) || (b_inf && a_zero))   res_o = NAN_W;
            else if (a_inf || b_inf) res_o = {sa ^ sb, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            else if (a_zero || b_zero)                         res_o = '0;
         end
         default: res_o = '0;
      endcase
   end

   // R2, R9, R10: output encodings seen at the ports
   always_comb begin
      if (!valid_o)
         a_r2_invalid_zero: assert (res_o == '0)
            else $error("undefined operation produced a non-zero word");
      if (res_o[WW-2 -: EXP_W] == '0)
         a_r9_zero_word: assert (res_o == '0)
            else $error("zero exponent field with non-zero word");
      if (valid_o && (a_nan || b_nan))
         a_r10_nan_propagates: assert (res_o == NAN_W)
            else $error("NaN input did not give NaN");
   end

endmodule

// File: tb/tb_fpu12_arith.sv
`timescale 1ns/1ps
module tb_fpu12_arith;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] a, b, res;
   logic [1:0]  op;
   logic        valid;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done  = 1'b0;

   always #4 clk = ~clk;

   fpu12_arith dut (.a_i(a), .b_i(b), .op_i(op), .res_o(res), .valid_o(valid));

   function automatic real pow2(int k);
      real r = 1.0;
      if (k >= 0) repeat (k) r = r * 2.0;
      else        repeat (-k) r = r / 2.0;
      return r;
   endfunction

   function automatic real to_real(logic [11:0] w);
      int  e = int'(w[10:7]);
      real v;
      if (e == 0) return 0.0;
      v = (1.0 + real'(int'(w[6:0])) / 128.0) * pow2(e - 7);
      return w[11] ? -v : v;
   endfunction

   function automatic logic [11:0] from_real(real x);
      logic s;
      real  m, sc, fr;
      int   e, q, bexp;
      if (x == 0.0) return 12'h000;
      s = (x < 0.0);
      m = s ? -x : x;
      e = 0;
      while (m >= 2.0) begin m = m / 2.0; e++; end
      while (m < 1.0)  begin m = m * 2.0; e--; end
      sc = m * 128.0;
      q  = $rtoi(sc);
      fr = sc - real'(q);
      if (fr > 0.5 || (fr == 0.5 && q[0])) q++;
      if (q == 256) begin q = 128; e++; end
      bexp = e + 7;
      if (bexp >= 15) return {s, 4'hF, 7'h00};
      if (bexp <= 0)  return 12'h000;
      return {s, bexp[3:0], q[6:0]};
   endfunction

   function automatic logic [11:0] model(logic [11:0] x, logic [11:0] y, logic [1:0] o);
      logic xn, yn, xi, yi, xz, yz, ys;
      if (o == 2'd3) return 12'h000;
      xz = (x[10:7] == 4'h0);
      yz = (y[10:7] == 4'h0);
      xi = (x[10:7] == 4'hF) && (x[6:0] == 0);
      yi = (y[10:7] == 4'hF) && (y[6:0] == 0);
      xn = (x[10:7] == 4'hF) && (x[6:0] != 0);
      yn = (y[10:7] == 4'hF) && (y[6:0] != 0);
      if (xn || yn) return 12'h7FF;
      if (o == 2'd2) begin
         if ((xi && yz) || (yi && xz)) return 12'h7FF;
         if (xi || yi) return {x[11] ^ y[11], 4'hF, 7'h00};
         if (xz || yz) return 12'h000;
         return from_real(to_real(x) * to_real(y));
      end
      ys = y[11] ^ (o == 2'd1);
      if (xi && yi && x[11] != ys) return 12'h7FF;
      if (xi) return x;
      if (yi) return {ys, 4'hF, 7'h00};
      if (xz && yz) return 12'h000;
      if (xz) return {ys, y[10:0]};
      if (yz) return x;
      return from_real(to_real(x) + to_real({ys, y[10:0]}));
   endfunction

   task automatic check(string tag, logic [11:0] got, logic [11:0] exp_v,
                        logic [11:0] x, logic [11:0] y, logic [1:0] o);
      n_chk++;
      if (got !== exp_v) begin
         n_bad++;
         $display("FAIL %s: a=%h b=%h op=%0d actual=%h expected=%h", tag, x, y, o, got, exp_v);
      end
   endtask

   task automatic apply(logic [11:0] x, logic [11:0] y, logic [1:0] o, string tag);
      @(negedge clk);
      a = x; b = y; op = o;
      #2;
      check(tag, res, model(x, y, o), x, y, o);
   endtask

   task automatic expect_word(logic [11:0] x, logic [11:0] y, logic [1:0] o,
                              logic [11:0] exp_v, string tag);
      @(negedge clk);
      a = x; b = y; op = o;
      #2;
      check(tag, res, exp_v, x, y, o);
   endtask

   initial begin
      #1500000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      a = '0; b = '0; op = 2'd0;
      repeat (2) @(posedge clk);
      rst = 1'b0;

      // R1/R9: quiet inputs give the zero word with a valid flag
      @(negedge clk); #2;
      check("R1 idle zero", res, 12'h000, a, b, op);
      check("R2 idle valid", {11'h0, valid}, 12'h001, a, b, op);

      // R2: undefined code
      @(negedge clk); a = 12'h3C0; b = 12'h380; op = 2'd3; #2;
      check("R2 op3 result", res, 12'h000, a, b, op);
      check("R2 op3 valid", {11'h0, valid}, 12'h000, a, b, op);

      // R6: ties to even
      expect_word(12'h500, 12'h100, 2'd0, 12'h500, "R6 tie even down");
      expect_word(12'h501, 12'h100, 2'd0, 12'h502, "R6 tie odd up");
      // R7: rounding carry into exponent
      expect_word(12'h5FF, 12'h180, 2'd0, 12'h600, "R7 carry");
      // R8: overflow to infinity
      expect_word(12'h77F, 12'h77F, 2'd0, 12'h780, "R8 add overflow");
      expect_word(12'h700, 12'h700, 2'd2, 12'h780, "R8 mul overflow");
      expect_word(12'hF00, 12'h700, 2'd2, 12'hF80, "R8 neg overflow");
      // R9: zero results
      expect_word(12'h3A5, 12'h3A5, 2'd1, 12'h000, "R9 cancel");
      expect_word(12'h080, 12'h080, 2'd2, 12'h000, "R9 underflow");
      expect_word(12'h3C0, 12'h000, 2'd2, 12'h000, "R9 mul zero");
      // R1: exponent-zero operand with fraction bits acts as zero
      expect_word(12'h3C0, 12'h055, 2'd0, 12'h3C0, "R1 flush input");
      // R10: NaN cases
      expect_word(12'h781, 12'h380, 2'd0, 12'h7FF, "R10 nan in");
      expect_word(12'h780, 12'h780, 2'd1, 12'h7FF, "R10 inf-inf");
      expect_word(12'h780, 12'h000, 2'd2, 12'h7FF, "R10 inf*0");
      // R11: infinity and zero operands
      expect_word(12'h780, 12'h3C0, 2'd0, 12'h780, "R11 inf+x");
      expect_word(12'hF80, 12'h380, 2'd2, 12'hF80, "R11 -inf*x");
      expect_word(12'h000, 12'h3C0, 2'd1, 12'hBC0, "R11 0-x");
      // R4: subtract equals add with flipped sign
      expect_word(12'h3C0, 12'h380, 2'd1, 12'h300, "R4 1.5-1");
      // R3/R5 simple values
      expect_word(12'h380, 12'h380, 2'd0, 12'h400, "R3 1+1");
      expect_word(12'h3C0, 12'h3C0, 2'd2, 12'h410, "R5 1.5*1.5");

      // Sweep: every first operand against a spread of second operands
      for (int i = 0; i < 4096; i++) begin
         for (int k = 0; k < 8; k++) begin
            logic [11:0] x, y;
            x = 12'(i);
            if (k < 4) y = 12'(i + k * 37) ^ ((k % 2 == 1) ? 12'h800 : 12'h000);
            else       y = 12'(i * 2731 + k * 977 + 13 * k * k);
            apply(x, y, 2'd0, "R3 sweep add");
            apply(x, y, 2'd1, "R4 sweep sub");
            apply(x, y, 2'd2, "R5 sweep mul");
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule